// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds a 24-hour time of day and a full calendar in packed BCD bytes: seconds, minutes, hours, a day-of-week counter, date, month and a two-digit year. A free-running prescaler on the system clock makes one advance per second. A carry then moves through the fields, and the month length, including the February leap day, decides when the date wraps.

Software sets the time through a parallel load strobe. The strobe writes every field in one cycle, forces the reserved bits to zero and restarts the sub-second prescaler. Bit 7 of the seconds byte is a stop flag that freezes the prescaler and the whole calendar. Bit 6 of the day byte turns on a test mode. In that mode, while the counter runs, the seconds LSB on the output shows a 512 Hz square wave taken from the same prescaler.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00, with the stop and test bits clear.
- R2: Seconds and minutes count 00 to 59 and hours 00 to 23 in BCD. Seconds advance once per 2^PRESCALE_W clock cycles, and each field carries into the next when it wraps.
- R3: When hours wrap, the date advances. It wraps to 01 after 30 in months 04, 06, 09 and 11, after 28 in February of a non-leap year, and after 31 in every other month. The month then advances by one.
- R4: February has 29 days when the BCD year is a multiple of four, year 00 included.
- R5: The day-of-week field (day bits 2:0) advances by one at each midnight and wraps from 7 to 1.
- R6: The step after December 31 23:59:59 gives date 01 and month 01 and advances the year. Year 99 wraps to 00.
- R7: While seconds bit 7 (stop) is 1, no field and no part of the prescaler changes. Loading with stop clear resumes counting.
- R8: While day bit 6 (test) is 1 and stop is 0, seconds output bit 0 shows prescaler bit PRESCALE_W-10. That bit is 0 right after a load and toggles every 2^(PRESCALE_W-10) cycles, which is 512 Hz at one tick per second. While stop is 1, output bit 0 shows the stored seconds LSB.
- R9: A load strobe writes all fields in its cycle and clears the prescaler. The first seconds step comes exactly 2^PRESCALE_W cycles after the load edge.
- R10: A load stores these bits as 0: minutes bit 7, hours bits 7:6, day bits 7 and 5:3, date bits 7:6, month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load strobe for all fields |
| ldSec | input | 8 | Load value: stop bit and BCD seconds |
| ldMin | input | 8 | Load value: BCD minutes |
| ldHour | input | 8 | Load value: BCD hours |
| ldDay | input | 8 | Load value: test bit and day of week |
| ldDate | input | 8 | Load value: BCD date |
| ldMonth | input | 8 | Load value: BCD month |
| ldYear | input | 8 | Load value: BCD year |
| secOut | output | 8 | Stop bit and BCD seconds, LSB replaced in test mode |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | BCD hours |
| dayOut | output | 8 | Test bit and day of week |
| dateOut | output | 8 | BCD date |
| monthOut | output | 8 | BCD month |
| yearOut | output | 8 | BCD year |

## Verification
The bench builds the block with PRESCALE_W = 11, so one second lasts 2048 cycles and the 512 Hz test output toggles every two cycles. With a second that short, many separate rollovers fit in one run: months with 30 and 31 days, February in leap and common years including year 00, the year 99 wrap and the day-of-week wrap. Each one starts from a load placed one second before the boundary. The short second also lets the bench count the cycle of the first step after a load and watch the test toggle phase edge by edge.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic tick;
    logic load;
  } calStrobes_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
  import bcd_cal_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic        stopBit,
  output calStrobes_t strobes,
  output logic        testPhase
);
  localparam int TEST_BIT = PRESCALE_W - 10;
  localparam logic [PRESCALE_W-1:0] LAST_CNT = '1;

  logic [PRESCALE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (loadEn)  preCnt <= '0;
    else if (!stopBit) preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobes.load = loadEn;
    strobes.tick = !loadEn && !stopBit && (preCnt == LAST_CNT);
  end

  assign testPhase = preCnt[TEST_BIT];

  // R9: a load restarts the sub-second count
  assert_prescale_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (preCnt == '0));

  // R7: stopped prescaler does not move
  assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !loadEn) |=> $stable(preCnt));

endmodule

// File: rtl/bcd_cal_datapath.sv
module bcd_cal_datapath
  import bcd_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  calStrobes_t strobes,
  input  logic        testPhase,
  input  logic [7:0]  ldSec,
  input  logic [7:0]  ldMin,
  input  logic [7:0]  ldHour,
  input  logic [7:0]  ldDay,
  input  logic [7:0]  ldDate,
  input  logic [7:0]  ldMonth,
  input  logic [7:0]  ldYear,
  output logic        stopBit,
  output logic [7:0]  secOut,
  output logic [7:0]  minOut,
  output logic [7:0]  hourOut,
  output logic [7:0]  dayOut,
  output logic [7:0]  dateOut,
  output logic [7:0]  monthOut,
  output logic [7:0]  yearOut
);
  localparam int TOD_N = 3;
  localparam logic [TOD_N-1:0][7:0] TOD_LIMIT = {8'h23, 8'h59, 8'h59};
  localparam logic [TOD_N-1:0][7:0] TOD_MASK  = {8'h3F, 8'h7F, 8'hFF};

  logic [TOD_N-1:0][7:0] todQ;
  logic [TOD_N-1:0][7:0] ldTod;
  logic [TOD_N:0]        carry;
  logic [7:0] dayQ, dateQ, monthQ, yearQ;

  assign ldTod = {ldHour, ldMin, ldSec} & TOD_MASK;
  assign carry[0] = strobes.tick;

  // seconds, minutes, hours: one ripple stage each
  for (genvar i = 0; i < TOD_N; i++) begin : todChain
    logic [7:0] fieldQ;
    logic       roll;
    assign roll = carry[i] && (fieldQ == TOD_LIMIT[i]);
    assign carry[i+1] = roll;
    assign todQ[i] = fieldQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             fieldQ <= 8'h00;
      else if (strobes.load) fieldQ <= ldTod[i];
      else if (roll)         fieldQ <= 8'h00;
      else if (carry[i])     fieldQ <= bcdInc(fieldQ);
    end
  end

  logic       dayCarry, dateRoll, monthRoll, leapYear;
  logic [1:0] leapSum;
  logic [7:0] lastDate;
  logic [2:0] nextDow;

  assign dayCarry = carry[TOD_N];
  assign leapSum  = yearQ[1:0] + {yearQ[4], 1'b0};
  assign leapYear = (leapSum == 2'b00);

  always_comb begin
    case (monthQ)
      8'h02:                      lastDate = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDate = 8'h30;
      default:                    lastDate = 8'h31;
    endcase
  end

  assign dateRoll  = dayCarry && (dateQ >= lastDate);
  assign monthRoll = dateRoll && (monthQ >= 8'h12);
  assign nextDow   = (dayQ[2:0] == 3'd7) ? 3'd1 : dayQ[2:0] + 3'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dayQ   <= 8'h01;
      dateQ  <= 8'h01;
      monthQ <= 8'h01;
      yearQ  <= 8'h00;
    end else if (strobes.load) begin
      dayQ   <= ldDay & 8'h47;
      dateQ  <= ldDate & 8'h3F;
      monthQ <= ldMonth & 8'h1F;
      yearQ  <= ldYear;
    end else if (dayCarry) begin
      dayQ  <= {dayQ[7:3], nextDow};
      dateQ <= dateRoll ? 8'h01 : bcdInc(dateQ);
      if (dateRoll) monthQ <= monthRoll ? 8'h01 : bcdInc(monthQ);
      if (monthRoll) yearQ <= (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
    end
  end

  assign stopBit  = todQ[0][7];
  assign secOut   = {todQ[0][7:1], (dayQ[6] && !todQ[0][7]) ? testPhase : todQ[0][0]};
  assign minOut   = todQ[1];
  assign hourOut  = todQ[2];
  assign dayOut   = dayQ;
  assign dateOut  = dateQ;
  assign monthOut = monthQ;
  assign yearOut  = yearQ;

  // R2: without a tick or load nothing in the calendar moves
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.load) |=> ($stable(todQ) && $stable(dateQ) && $stable(dayQ)
                                          && $stable(monthQ) && $stable(yearQ)));

  // R10: reserved bits are zero after a load
  assert_load_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (todQ[1][7] == 1'b0 && todQ[2][7:6] == 2'b00 && dayQ[7] == 1'b0 &&
                      dayQ[5:3] == 3'b000 && dateQ[7:6] == 2'b00 && monthQ[7:5] == 3'b000));

  // R5: a running weekday never becomes zero
  assert_dow_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && dayQ[2:0] != 3'd0) |=> (dayQ[2:0] != 3'd0));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [7:0] ldDay,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMonth,
  input  logic [7:0] ldYear,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut
);
  calStrobes_t strobes;
  logic        testPhase;
  logic        stopBit;

  bcd_cal_ctrl #(.PRESCALE_W(PRESCALE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stopBit(stopBit),
    .strobes(strobes), .testPhase(testPhase)
  );

  bcd_cal_datapath data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .testPhase(testPhase),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDay(ldDay),
    .ldDate(ldDate), .ldMonth(ldMonth), .ldYear(ldYear),
    .stopBit(stopBit), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dayOut(dayOut), .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
  );

endmodule

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 11;
  localparam int TPS = 1 << PW;
  localparam int TEST_DIV = TPS / 1024;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [7:0] ldSec = 0, ldMin = 0, ldHour = 0, ldDay = 0, ldDate = 0, ldMonth = 0, ldYear = 0;
  logic [7:0] secOut, minOut, hourOut, dayOut, dateOut, monthOut, yearOut;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit modelLive = 0;

  // reference state
  int mSec, mMin, mHour, mDow, mDate, mMon, mYear, mPres;
  bit mStop, mFt;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar #(.PRESCALE_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDay(ldDay),
    .ldDate(ldDate), .ldMonth(ldMonth), .ldYear(ldYear),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dayOut(dayOut),
    .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int monthDays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep();
    mSec++;
    if (mSec < 60) return;
    mSec = 0; mMin++;
    if (mMin < 60) return;
    mMin = 0; mHour++;
    if (mHour < 24) return;
    mHour = 0;
    mDow = (mDow == 7) ? 1 : mDow + 1;
    mDate++;
    if (mDate <= monthDays(mMon, mYear)) return;
    mDate = 1; mMon++;
    if (mMon <= 12) return;
    mMon = 1;
    mYear = (mYear + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mMin = 0; mHour = 0; mDow = 1; mDate = 1; mMon = 1; mYear = 0;
      mPres = 0; mStop = 0; mFt = 0;
    end else if (loadEn) begin
      mStop = ldSec[7];
      mSec  = fromBcd(ldSec & 8'h7F);
      mMin  = fromBcd(ldMin & 8'h7F);
      mHour = fromBcd(ldHour & 8'h3F);
      mDow  = int'(ldDay[2:0]);
      mFt   = ldDay[6];
      mDate = fromBcd(ldDate & 8'h3F);
      mMon  = fromBcd(ldMonth & 8'h1F);
      mYear = fromBcd(ldYear);
      mPres = 0;
    end else if (!mStop) begin
      if (mPres == TPS - 1) begin
        mPres = 0;
        modelStep();
      end else begin
        mPres++;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison with the reference model
  always @(negedge clk) begin
    if (rstN && modelLive) begin
      logic [7:0] s;
      s = toBcd(mSec);
      s[7] = mStop;
      if (mFt && !mStop) s[0] = 1'((mPres / TEST_DIV) % 2);
      chk("R2/R7/R8 seconds", secOut, s);
      chk("R2 minutes", minOut, toBcd(mMin));
      chk("R2 hours", hourOut, toBcd(mHour));
      chk("R5 day", dayOut, {1'b0, mFt, 3'b000, 3'(mDow)});
      chk("R3 date", dateOut, toBcd(mDate));
      chk("R6 month", monthOut, toBcd(mMon));
      chk("R6 year", yearOut, toBcd(mYear));
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic doLoad(input logic [7:0] s, m, h, d, dt, mo, y);
    @(negedge clk);
    ldSec = s; ldMin = m; ldHour = h; ldDay = d; ldDate = dt; ldMonth = mo; ldYear = y;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    modelLive = 1;
    // R1 reset values
    chk("R1 sec", secOut, 8'h00);
    chk("R1 min", minOut, 8'h00);
    chk("R1 hour", hourOut, 8'h00);
    chk("R1 day", dayOut, 8'h01);
    chk("R1 date", dateOut, 8'h01);
    chk("R1 month", monthOut, 8'h01);
    chk("R1 year", yearOut, 8'h00);
    waitCycles(2 * TPS + 10);

    // R9 step timing, R5 weekday wrap, R3 30-day month
    doLoad(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h23);
    waitCycles(TPS - 1);
    chk("R9 no step before full second", secOut, 8'h59);
    waitCycles(1);
    chk("R9 step at full second", secOut, 8'h00);
    chk("R5 day wraps 7 to 1", dayOut, 8'h01);
    chk("R3 date after April 30", dateOut, 8'h01);
    chk("R3 month after April 30", monthOut, 8'h05);

    // R4 leap year Feb 28 -> 29
    doLoad(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    waitCycles(TPS);
    chk("R4 Feb 29 in year 24", dateOut, 8'h29);
    chk("R5 day advance", dayOut, 8'h04);

    // R4 Feb 29 -> Mar 1
    doLoad(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    waitCycles(TPS);
    chk("R4 month after Feb 29", monthOut, 8'h03);
    chk("R4 date after Feb 29", dateOut, 8'h01);

    // R3 common year Feb 28 -> Mar 1
    doLoad(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    waitCycles(TPS);
    chk("R3 month after Feb 28 year 23", monthOut, 8'h03);

    // R4 year 00 is leap
    doLoad(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    waitCycles(TPS);
    chk("R4 Feb 29 in year 00", dateOut, 8'h29);

    // R6 year 99 wraps
    doLoad(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
    waitCycles(TPS);
    chk("R6 year wraps to 00", yearOut, 8'h00);
    chk("R6 month to 01", monthOut, 8'h01);
    chk("R6 date to 01", dateOut, 8'h01);

    // R6 ordinary new year, BCD digit carry in year
    doLoad(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h29);
    waitCycles(TPS);
    chk("R6 year 29 to 30", yearOut, 8'h30);

    // R2 hour digit carry, R3 31-day January
    doLoad(8'h59, 8'h59, 8'h09, 8'h01, 8'h31, 8'h01, 8'h25);
    waitCycles(TPS);
    chk("R2 hours 09 to 10", hourOut, 8'h10);
    doLoad(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h25);
    waitCycles(TPS);
    chk("R3 month after Jan 31", monthOut, 8'h02);

    // R7 stop freezes counting
    doLoad(8'hA5, 8'h10, 8'h10, 8'h03, 8'h15, 8'h06, 8'h25);
    waitCycles(TPS + 100);
    chk("R7 stopped seconds hold", secOut, 8'hA5);
    doLoad(8'h25, 8'h10, 8'h10, 8'h03, 8'h15, 8'h06, 8'h25);
    waitCycles(TPS);
    chk("R7 counting resumes", secOut, 8'h26);

    // R10 reserved bits cleared on load
    doLoad(8'h10, 8'hC5, 8'hD2, 8'hB9, 8'hD5, 8'hE6, 8'h42);
    chk("R10 minutes bit 7", minOut, 8'h45);
    chk("R10 hours bits 7:6", hourOut, 8'h12);
    chk("R10 day bits 7 and 5:3", dayOut, 8'h01);
    chk("R10 date bits 7:6", dateOut, 8'h15);
    chk("R10 month bits 7:5", monthOut, 8'h06);

    // R8 test toggle phase
    doLoad(8'h11, 8'h00, 8'h00, 8'h42, 8'h01, 8'h01, 8'h25);
    chk("R8 phase low after load", secOut, 8'h10);
    waitCycles(TEST_DIV);
    chk("R8 phase high", secOut, 8'h11);
    waitCycles(TEST_DIV);
    chk("R8 phase low again", secOut, 8'h10);
    waitCycles(2 * TPS + 7);
    doLoad(8'h91, 8'h00, 8'h00, 8'h42, 8'h01, 8'h01, 8'h25);
    chk("R8 stopped shows stored LSB", secOut, 8'h91);
    waitCycles(3);
    chk("R8 stopped LSB steady", secOut, 8'h91);

    // long run through a minute boundary
    doLoad(8'h55, 8'h59, 8'h12, 8'h06, 8'h10, 8'h10, 8'h25);
    waitCycles(8 * TPS);
    chk("R2 minutes carry into hour", minOut, 8'h00);
    chk("R2 hour after carry", hourOut, 8'h13);

    summary();
    $finish;
  end

endmodule